// File: doc/BRIEF.md
# IO Channel Freeze and Thaw Sequencer

This block drives the pad and calibration controls of one high-speed IO channel through an ordered freeze sequence and an ordered thaw sequence. A one-cycle freeze request or thaw request starts a sequence. The block then applies each step's control changes at fixed points in time. Short gaps between steps are counted in system-clock cycles. The two long waits of the thaw path are counted in ticks from a slow reference oscillator. Those ticks arrive as one-cycle pulses that are already synchronous to the system clock.

On the way down, the block first freezes the pads. It then puts the regulator and the on-chip termination into reset, and finally stops calibration and resets the delay-locked loop. The thaw path undoes this in a different order. It releases the loop reset, starts termination calibration and lets it run for a long tick-counted interval. Next it releases bus-hold and the termination reset, waits a short tick-counted settle time, and then releases the pads and the regulator reset in stages. All control outputs come from flops. A busy flag covers each sequence, and a frozen flag reports the resting state.

Control encoding: `slew_n_o`, `pullup_n_o`, `tristate_n_o` and `bushold_n_o` are active low (0 = applied). `cfg_done_o`, `reg_rst_o`, `term_rst_o`, `cal_start_o` and `loop_rst_o` are active high. Frozen rest: loop_rst=1, cal_start=0, term_rst=1, reg_rst=1, cfg_done=0, all four active-low controls 0. Thawed rest: loop_rst=0, cal_start=1, term_rst=0, reg_rst=0, cfg_done=1, all four active-low controls 1.

Top module: `io_freeze_seq`

## Requirements
- R1: During and after reset, and before any request, every control sits at the frozen rest value, frozen_o=1 and busy_o=0.
- R2: A freeze request accepted at a clock edge drives slew_n_o, pullup_n_o and tristate_n_o to 0 at that edge. busy_o rises at the same edge.
- R3: GAP_CYC cycles after the freeze request is accepted, bushold_n_o=0, cfg_done_o=0, reg_rst_o=1 and term_rst_o=1. GAP_CYC cycles after that, cal_start_o=0 and loop_rst_o=1. In that same cycle frozen_o rises and busy_o falls.
- R4: An accepted thaw request drops loop_rst_o at the accepting edge and raises busy_o. GAP_CYC cycles later, cal_start_o rises.
- R5: At the edge that samples the CAL_TICKS-th oscillator tick after cal_start_o rose, bushold_n_o=1, cfg_done_o=1 and term_rst_o=0.
- R6: At the edge that samples the SETTLE_TICKS-th tick after that step, pullup_n_o=1 and tristate_n_o=1.
- R7: GAP_CYC cycles after R6, reg_rst_o=0. GAP_CYC cycles after that, slew_n_o=1. In that same cycle frozen_o falls and busy_o falls.
- R8: A tick counts toward a wait only if the block samples it while that wait is in progress. A tick at the edge where the wait starts, or during short gaps or idle, does not count. With a tick on every cycle, bushold_n_o rises exactly CAL_TICKS cycles after cal_start_o.
- R9: While busy_o=1, freeze and thaw requests are ignored, including one sampled at the edge that ends the sequence.
- R10: A freeze request while frozen, or a thaw request while thawed, is ignored: busy_o stays 0 and the controls do not move.
- R11: When both requests arrive in one cycle, the freeze request wins. While thawed this starts a freeze. While frozen nothing happens.
- R12: While idle and with no request accepted, no control output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_req_i | input | 1 | Freeze request pulse |
| thaw_req_i | input | 1 | Thaw request pulse |
| osc_tick_i | input | 1 | Synchronized reference-oscillator tick, one cycle wide |
| slew_n_o | output | 1 | Slew-rate enable, active low |
| pullup_n_o | output | 1 | Weak pull-up enable, active low |
| tristate_n_o | output | 1 | Output tristate, active low |
| bushold_n_o | output | 1 | Bus-hold enable, active low |
| cfg_done_o | output | 1 | Configuration done |
| reg_rst_o | output | 1 | Regulator reset |
| term_rst_o | output | 1 | On-chip termination reset |
| cal_start_o | output | 1 | Termination calibration start / bias enable |
| loop_rst_o | output | 1 | Delay-locked-loop reset |
| busy_o | output | 1 | A sequence is in progress |
| frozen_o | output | 1 | Channel rests frozen |

## Verification
Two things can land on one clock edge. A request can arrive at the same edge that completes a sequence. An oscillator tick can arrive at the same edge that starts a tick wait, including the edge where the calibration wait hands over to the settle wait. The bench holds a freeze request high across the last thaw step, and it runs one thaw with a tick on every cycle. A behavioural model advances one step per clock, and every output is compared with it on every cycle. A separate measurement checks that the calibration interval is exactly CAL_TICKS cycles when a tick arrives on every cycle.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int unsigned NCTRL = 9;
  typedef logic [NCTRL-1:0] ctrl_t;

  // bit positions inside ctrl_t
  localparam int unsigned B_SLEW_N   = 0;
  localparam int unsigned B_PULL_N   = 1;
  localparam int unsigned B_TRI_N    = 2;
  localparam int unsigned B_HOLD_N   = 3;
  localparam int unsigned B_CFG_DONE = 4;
  localparam int unsigned B_REG_RST  = 5;
  localparam int unsigned B_TERM_RST = 6;
  localparam int unsigned B_CAL      = 7;
  localparam int unsigned B_LOOP_RST = 8;

  localparam ctrl_t CTRL_FROZEN = 9'b101100000;
  localparam ctrl_t CTRL_THAWED = 9'b010011111;

  typedef enum logic [1:0] {W_END, W_GAP, W_CAL, W_SETTLE} wait_e;

  typedef struct packed {
    ctrl_t mask;
    ctrl_t val;
    wait_e wt;
  } step_t;

  function automatic step_t step_of(input logic thaw, input logic [2:0] idx);
    step_t s;
    s = '{mask: '0, val: '0, wt: W_END};
    case ({thaw, idx})
      4'b0_000: s = '{mask: 9'b000000111, val: 9'b000000000, wt: W_GAP};
      4'b0_001: s = '{mask: 9'b001111000, val: 9'b001100000, wt: W_GAP};
      4'b0_010: s = '{mask: 9'b110000000, val: 9'b100000000, wt: W_END};
      4'b1_000: s = '{mask: 9'b100000000, val: 9'b000000000, wt: W_GAP};
      4'b1_001: s = '{mask: 9'b010000000, val: 9'b010000000, wt: W_CAL};
      4'b1_010: s = '{mask: 9'b001011000, val: 9'b000011000, wt: W_SETTLE};
      4'b1_011: s = '{mask: 9'b000000110, val: 9'b000000110, wt: W_GAP};
      4'b1_100: s = '{mask: 9'b000100000, val: 9'b000000000, wt: W_GAP};
      4'b1_101: s = '{mask: 9'b000000001, val: 9'b000000001, wt: W_END};
      default:  s = '{mask: '0, val: '0, wt: W_END};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/frz_gap_timer.sv
module frz_gap_timer #(
  parameter int unsigned GAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  output logic done_o
);
  localparam int unsigned W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= W'(GAP_CYC - 1);
    else if (active_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = active_i && (cnt_q == '0);

  // R3: a short gap never counts beyond its load value
  a_r3_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !active_i |=> $stable(cnt_q));
endmodule

// File: rtl/frz_tick_timer.sv
module frz_tick_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  input  logic         active_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (start_i)                            cnt_q <= load_i;
    else if (active_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = active_i && tick_i && (cnt_q == '0);

  // R8: ticks outside an active wait leave the count alone
  a_r8_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !(active_i && tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/frz_ctrl_regs.sv
module frz_ctrl_regs
  import frz_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  ctrl_t mask_i,
  input  ctrl_t val_i,
  output ctrl_t ctrl_o
);
  for (genvar i = 0; i < NCTRL; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= CTRL_FROZEN[i];
      else if (step_i && mask_i[i]) q <= val_i[i];
    end
    assign ctrl_o[i] = q;
  end
endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
  import frz_pkg::*;
#(
  parameter int unsigned GAP_CYC      = 2,
  parameter int unsigned CAL_TICKS    = 1000,
  parameter int unsigned SETTLE_TICKS = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_req_i,
  input  logic thaw_req_i,
  input  logic osc_tick_i,
  output logic slew_n_o,
  output logic pullup_n_o,
  output logic tristate_n_o,
  output logic bushold_n_o,
  output logic cfg_done_o,
  output logic reg_rst_o,
  output logic term_rst_o,
  output logic cal_start_o,
  output logic loop_rst_o,
  output logic busy_o,
  output logic frozen_o
);
  localparam int unsigned TICK_MAX = (CAL_TICKS > SETTLE_TICKS) ? CAL_TICKS : SETTLE_TICKS;
  localparam int unsigned TICK_W   = $clog2(TICK_MAX + 1);

  logic       run_q, thaw_q, frozen_q;
  logic [2:0] idx_q;
  wait_e      wt_q;

  logic accept_frz, accept_thw, accept;
  logic gap_done, tick_done, wait_done, fire;
  logic dir_n;
  logic [2:0] idx_n;
  step_t step;
  logic gap_start, gap_active, tick_start, tick_active;
  logic [TICK_W-1:0] tick_load;
  ctrl_t ctrl;

  // freeze wins over thaw; redundant requests drop
  assign accept_frz = !run_q && freeze_req_i && !frozen_q;
  assign accept_thw = !run_q && thaw_req_i && !freeze_req_i && frozen_q;
  assign accept     = accept_frz || accept_thw;

  assign wait_done = run_q && ((wt_q == W_GAP) ? gap_done : tick_done);
  assign fire      = accept || wait_done;
  assign dir_n     = accept ? accept_thw : thaw_q;
  assign idx_n     = accept ? 3'd0 : 3'(idx_q + 3'd1);
  assign step      = step_of(dir_n, idx_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      thaw_q   <= 1'b0;
      frozen_q <= 1'b1;
      idx_q    <= '0;
      wt_q     <= W_END;
    end else if (fire) begin
      idx_q  <= idx_n;
      thaw_q <= dir_n;
      wt_q   <= step.wt;
      run_q  <= (step.wt != W_END);
      if (step.wt == W_END) frozen_q <= !dir_n;
    end
  end

  assign gap_start   = fire && (step.wt == W_GAP);
  assign gap_active  = run_q && (wt_q == W_GAP);
  assign tick_start  = fire && ((step.wt == W_CAL) || (step.wt == W_SETTLE));
  assign tick_active = run_q && ((wt_q == W_CAL) || (wt_q == W_SETTLE));
  assign tick_load   = (step.wt == W_CAL) ? TICK_W'(CAL_TICKS - 1) : TICK_W'(SETTLE_TICKS - 1);

  frz_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (gap_start),
    .active_i (gap_active),
    .done_o   (gap_done)
  );

  frz_tick_timer #(.W(TICK_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tick_start),
    .load_i   (tick_load),
    .active_i (tick_active),
    .tick_i   (osc_tick_i),
    .done_o   (tick_done)
  );

  frz_ctrl_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (fire),
    .mask_i (step.mask),
    .val_i  (step.val),
    .ctrl_o (ctrl)
  );

  assign slew_n_o     = ctrl[B_SLEW_N];
  assign pullup_n_o   = ctrl[B_PULL_N];
  assign tristate_n_o = ctrl[B_TRI_N];
  assign bushold_n_o  = ctrl[B_HOLD_N];
  assign cfg_done_o   = ctrl[B_CFG_DONE];
  assign reg_rst_o    = ctrl[B_REG_RST];
  assign term_rst_o   = ctrl[B_TERM_RST];
  assign cal_start_o  = ctrl[B_CAL];
  assign loop_rst_o   = ctrl[B_LOOP_RST];
  assign busy_o       = run_q;
  assign frozen_o     = frozen_q;

  a_r3_frozen_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && frozen_o |-> ctrl == CTRL_FROZEN);
  a_r7_thawed_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !frozen_o |-> ctrl == CTRL_THAWED);
  a_r5_cal_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bushold_n_o) |-> cal_start_o && !loop_rst_o);
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !wait_done |=> busy_o);
  a_r10_redundant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && frozen_o && freeze_req_i |=> !busy_o);
  a_r11_freeze_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !frozen_o && freeze_req_i && thaw_req_i |=> busy_o && !slew_n_o && !loop_rst_o);
  a_r12_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !accept |=> $stable(ctrl));
endmodule

// File: tb/io_freeze_seq_test.sv
`timescale 1ns/1ps
module io_freeze_seq_test;
  localparam int GAP = 2;
  localparam int CAL = 1000;
  localparam int SET = 33;

  logic clk = 0, rst_n = 0;
  logic freeze_req = 0, thaw_req = 0, osc_tick = 0;
  logic slew_n, pull_n, tri_n, hold_n, cfg_done, reg_rst, term_rst, cal, loop_rst, busy, frozen;

  always #10 clk = ~clk;

  io_freeze_seq #(.GAP_CYC(GAP), .CAL_TICKS(CAL), .SETTLE_TICKS(SET)) uut (
    .clk_i(clk), .rst_ni(rst_n), .freeze_req_i(freeze_req), .thaw_req_i(thaw_req),
    .osc_tick_i(osc_tick), .slew_n_o(slew_n), .pullup_n_o(pull_n), .tristate_n_o(tri_n),
    .bushold_n_o(hold_n), .cfg_done_o(cfg_done), .reg_rst_o(reg_rst), .term_rst_o(term_rst),
    .cal_start_o(cal), .loop_rst_o(loop_rst), .busy_o(busy), .frozen_o(frozen));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [10:0] act, logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // oscillator tick generator
  int tick_per = 5, tick_ph = 0;
  always @(negedge clk) begin
    if (tick_per <= 1) osc_tick = 1'b1;
    else begin
      tick_ph  = (tick_ph + 1) % tick_per;
      osc_tick = (tick_ph == 0);
    end
  end

  // behavioural reference model
  bit m_slew, m_pull, m_tri, m_hold, m_cfg, m_reg, m_term, m_cal, m_loop, m_busy, m_frz;
  bit m_thaw, m_tickwait;
  int m_step, m_left;
  string m_tag = "R1";

  task automatic m_apply();
    if (!m_thaw) begin
      case (m_step)
        0: begin m_slew = 0; m_pull = 0; m_tri = 0; m_left = GAP; m_tickwait = 0; m_busy = 1; m_tag = "R2"; end
        1: begin m_hold = 0; m_cfg = 0; m_reg = 1; m_term = 1; m_left = GAP; m_tag = "R3"; end
        default: begin m_cal = 0; m_loop = 1; m_busy = 0; m_frz = 1; m_tag = "R3"; end
      endcase
    end else begin
      case (m_step)
        0: begin m_loop = 0; m_left = GAP; m_tickwait = 0; m_busy = 1; m_tag = "R4"; end
        1: begin m_cal = 1; m_left = CAL; m_tickwait = 1; m_tag = "R4"; end
        2: begin m_hold = 1; m_cfg = 1; m_term = 0; m_left = SET; m_tickwait = 1; m_tag = "R5"; end
        3: begin m_pull = 1; m_tri = 1; m_left = GAP; m_tickwait = 0; m_tag = "R6"; end
        4: begin m_reg = 0; m_left = GAP; m_tag = "R7"; end
        default: begin m_slew = 1; m_busy = 0; m_frz = 0; m_tag = "R7"; end
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_loop, m_cal, m_term, m_reg, m_cfg, m_hold, m_tri, m_pull, m_slew} = 9'b101100000;
      m_busy = 0; m_frz = 1; m_step = 0; m_left = 0; m_thaw = 0; m_tickwait = 0; m_tag = "R1";
    end else if (!m_busy) begin
      if (freeze_req && !m_frz) begin m_thaw = 0; m_step = 0; m_apply(); end
      else if (thaw_req && !freeze_req && m_frz) begin m_thaw = 1; m_step = 0; m_apply(); end
      else if (freeze_req && thaw_req) m_tag = "R11";
      else if (freeze_req || thaw_req) m_tag = "R10";
    end else begin
      if (freeze_req || thaw_req) m_tag = "R9";
      if (!m_tickwait || osc_tick) m_left--;
      if (m_left == 0) begin m_step++; m_apply(); end
    end
  end

  // compare every cycle, R12 covered by idle cycles
  always @(negedge clk) begin
    if (rst_n && !finished)
      chk(m_tag,
          {loop_rst, cal, term_rst, reg_rst, cfg_done, hold_n, tri_n, pull_n, slew_n, busy, frozen},
          {m_loop, m_cal, m_term, m_reg, m_cfg, m_hold, m_tri, m_pull, m_slew, m_busy, m_frz});
  end

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic pulse(bit f, bit t);
    @(negedge clk); freeze_req = f; thaw_req = t;
    @(negedge clk); freeze_req = 0; thaw_req = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {loop_rst, cal, term_rst, reg_rst, cfg_done, hold_n, tri_n, pull_n, slew_n, busy, frozen},
        11'b101100000_01);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // thaw with requests injected while busy (R9)
    pulse(0, 1);
    repeat (10) @(negedge clk);
    pulse(1, 0);
    pulse(0, 1);
    repeat (2000) @(negedge clk);
    pulse(1, 1);
    wait_idle();

    // redundant thaw (R10)
    pulse(0, 1);
    repeat (5) @(negedge clk);

    // freeze, then redundant freeze (R10) and both-at-once while frozen (R11)
    pulse(1, 0);
    wait_idle();
    pulse(1, 0);
    repeat (5) @(negedge clk);
    pulse(1, 1);
    repeat (5) @(negedge clk);

    // R8: tick every cycle, calibration wait is exactly CAL cycles
    tick_per = 1;
    pulse(0, 1);
    while (!cal) @(negedge clk);
    begin
      int n = 0;
      while (!hold_n) begin @(negedge clk); n++; end
      chk("R8", 11'(n), 11'(CAL));
    end
    wait_idle();

    // R11: both while thawed starts a freeze
    pulse(1, 1);
    wait_idle();

    // thaw with slow ticks; freeze held across the final step (R9)
    tick_per = 7;
    pulse(0, 1);
    @(negedge clk); freeze_req = 1;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R9", {10'b0, busy}, 11'd1);
    freeze_req = 0;
    wait_idle();
    chk("R3", {10'b0, frozen}, 11'd1);

    summary();
  end
endmodule